// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds, for every hardware thread of a multithreaded front end, the fetch status state machine and the three program counters the fetch unit works from: the current PC, the next PC and the next-next PC. Each cycle it takes in several kinds of input. The four downstream stages (decode, rename, execute, commit) each send block and unblock pulses. Commit and decode can each send a squash request with a redirect address. The reorder buffer reports whether it is still squashing, and a global input reports a context switch. The fetch engine reports when it sends a cache request and when the response arrives. From all of this the block works out each thread's next status and its PC triple.

A stage scheduler reads the packed status codes and the stage-active output to decide whether the fetch stage should be clocked this cycle. Branch prediction, instruction decode and delay-slot bookkeeping belong to the neighbouring logic. The PCs move only on a redirect.

The per-thread states are Running, Idle, Squashing, Blocked, WaitRetry, WaitResponse, AccessComplete, TrapPending and QuiescePending. The block drives these transitions:

- Any state to Squashing on a commit squash, an ongoing reorder-buffer squash, or a decode squash taken.
- Any state except WaitResponse to Blocked when stalled.
- Blocked or Squashing back to Running.
- Running to WaitResponse on a cache request.
- WaitResponse to AccessComplete, or to Blocked when stalled, on a response.
- AccessComplete to Running.

Top module: `fetch_status_ctl`

## Requirements
- R1: After reset every thread is Running, all stall flags are clear, PC equals RESET_PC, next PC equals RESET_PC+4 and next-next PC equals RESET_PC+8.
- R2: Each thread has one sticky stall flag per downstream stage. Stage index 0 is decode, 1 rename, 2 execute, 3 commit. A block pulse sets the flag and an unblock pulse clears it. An unblock never comes in the same cycle as a block for that stage, and never while the flag is clear.
- R3: A commit squash outranks every other input. At the next edge it loads the PC triple from its target and puts the thread in Squashing.
- R4: When there is no commit squash but the reorder buffer is still squashing, the thread is Squashing after the edge and its PCs are unchanged.
- R5: A decode squash redirects the thread and enters Squashing only when the thread is not already in Squashing. When it is not taken, the PCs do not change.
- R6: A thread is stalled when the context switch input is high or any of its stall flags is set, counting a block pulse arriving in the same cycle. When no squash is taken, a stalled thread goes to Blocked unless it is in WaitResponse.
- R7: A thread in Blocked or Squashing that gets no squash and is not stalled returns to Running at the next edge.
- R8: On a redirect to target T, the PC becomes T, the next PC becomes T+4 and the next-next PC becomes T+8.
- R9: A Running thread goes to WaitResponse on a request-sent pulse. In WaitResponse, a response goes to AccessComplete, or to Blocked when the thread is stalled. AccessComplete goes to Running one cycle later. A response in any other state is ignored.
- R10: stage_active is high exactly when some thread with its thread_active bit set is in Running, Squashing or AccessComplete.
- R11: The status code is 4 bits: Running=0, Idle=1, Squashing=2, Blocked=3, WaitRetry=4, WaitResponse=5, AccessComplete=6, TrapPending=7, QuiescePending=8. It appears in status bits [4t+3:4t] for thread t.
- R12: Threads are independent. Inputs for one thread never change another thread's status or PCs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NUM_THREADS | Threads counted for stage_active |
| blk_dec | input | NUM_THREADS | Decode block pulse per thread |
| unblk_dec | input | NUM_THREADS | Decode unblock pulse per thread |
| blk_ren | input | NUM_THREADS | Rename block pulse per thread |
| unblk_ren | input | NUM_THREADS | Rename unblock pulse per thread |
| blk_exe | input | NUM_THREADS | Execute block pulse per thread |
| unblk_exe | input | NUM_THREADS | Execute unblock pulse per thread |
| blk_cmt | input | NUM_THREADS | Commit block pulse per thread |
| unblk_cmt | input | NUM_THREADS | Commit unblock pulse per thread |
| ctx_switch | input | 1 | Context switch in progress, stalls all threads |
| cmt_squash | input | NUM_THREADS | Commit squash request |
| cmt_target | input | NUM_THREADS*ADDR_W | Commit redirect address, thread t at [t*ADDR_W +: ADDR_W] |
| rob_squashing | input | NUM_THREADS | Reorder buffer still squashing |
| dec_squash | input | NUM_THREADS | Decode squash request |
| dec_target | input | NUM_THREADS*ADDR_W | Decode redirect address |
| req_sent | input | NUM_THREADS | Fetch engine sent a cache request |
| resp_ok | input | NUM_THREADS | Cache response arrived |
| status | output | NUM_THREADS*4 | Packed per-thread status codes |
| pc | output | NUM_THREADS*ADDR_W | Current PC per thread |
| npc | output | NUM_THREADS*ADDR_W | Next PC per thread |
| nnpc | output | NUM_THREADS*ADDR_W | Next-next PC per thread |
| stage_active | output | 1 | Fetch stage has work this cycle |

## Verification
Status, the PC triple and the stall flags are registered. An input applied in the cycle before clock edge k shows up on the outputs right after edge k. stage_active is decoded from the registered status without a further register, so it follows that same edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Every check therefore looks at the state one edge after its stimulus, and every expected value is worked out for that edge.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [3:0] {
        ST_RUN     = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SQUASH  = 4'd2,
        ST_BLOCK   = 4'd3,
        ST_WRETRY  = 4'd4,
        ST_WRESP   = 4'd5,
        ST_DONE    = 4'd6,
        ST_TRAP    = 4'd7,
        ST_QUIESCE = 4'd8
    } fstat_e;

    localparam int NUM_STAGES = 4;
    localparam int STAT_W     = 4;
endpackage

// File: rtl/fsc_stall_tracker.sv
module fsc_stall_tracker #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] set_i,
    input  logic [NS-1:0] clr_i,
    output logic [NS-1:0] flags_q,
    output logic [NS-1:0] flags_next
);
    // set has precedence only formally; legal traffic never overlaps
    assign flags_next = (flags_q & ~clr_i) | set_i;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_next;
    end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          STEP     = 4,
    parameter logic [31:0] RESET_PC = 32'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmt_sq,
    input  logic [ADDR_W-1:0] cmt_tgt,
    input  logic              rob_sq,
    input  logic              dec_sq,
    input  logic [ADDR_W-1:0] dec_tgt,
    input  logic              stalled,
    input  logic              req_sent,
    input  logic              resp_ok,
    output fstat_e            st_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] npc_q,
    output logic [ADDR_W-1:0] nnpc_q
);
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(STEP);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * STEP);
    localparam logic [ADDR_W-1:0] PC0   = ADDR_W'(RESET_PC);

    fstat_e            st_d;
    logic              redir;
    logic [ADDR_W-1:0] tgt;

    // next-state and redirect selection, priority order fixed
    always_comb begin
        st_d  = st_q;
        redir = 1'b0;
        tgt   = '0;
        if (cmt_sq) begin
            st_d  = ST_SQUASH;
            redir = 1'b1;
            tgt   = cmt_tgt;
        end else if (rob_sq) begin
            st_d = ST_SQUASH;
        end else if (dec_sq && st_q != ST_SQUASH) begin
            st_d  = ST_SQUASH;
            redir = 1'b1;
            tgt   = dec_tgt;
        end else if (stalled && st_q != ST_WRESP) begin
            st_d = ST_BLOCK;
        end else begin
            unique case (st_q)
                ST_BLOCK, ST_SQUASH: st_d = ST_RUN;
                ST_RUN:   if (req_sent) st_d = ST_WRESP;
                ST_WRESP: if (resp_ok)  st_d = stalled ? ST_BLOCK : ST_DONE;
                ST_DONE:  st_d = ST_RUN;
                default:  st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // PC triple register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= PC0;
            npc_q  <= PC0 + STEP1;
            nnpc_q <= PC0 + STEP2;
        end else if (redir) begin
            pc_q   <= tgt;
            npc_q  <= tgt + STEP1;
            nnpc_q <= tgt + STEP2;
        end
    end
endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
    import fsc_pkg::*;
#(
    parameter int          NUM_THREADS = 2,
    parameter int          ADDR_W      = 32,
    parameter int          INST_BYTES  = 4,
    parameter logic [31:0] RESET_PC    = 32'h100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_THREADS-1:0]        thread_active,
    input  logic [NUM_THREADS-1:0]        blk_dec,
    input  logic [NUM_THREADS-1:0]        unblk_dec,
    input  logic [NUM_THREADS-1:0]        blk_ren,
    input  logic [NUM_THREADS-1:0]        unblk_ren,
    input  logic [NUM_THREADS-1:0]        blk_exe,
    input  logic [NUM_THREADS-1:0]        unblk_exe,
    input  logic [NUM_THREADS-1:0]        blk_cmt,
    input  logic [NUM_THREADS-1:0]        unblk_cmt,
    input  logic                          ctx_switch,
    input  logic [NUM_THREADS-1:0]        cmt_squash,
    input  logic [NUM_THREADS*ADDR_W-1:0] cmt_target,
    input  logic [NUM_THREADS-1:0]        rob_squashing,
    input  logic [NUM_THREADS-1:0]        dec_squash,
    input  logic [NUM_THREADS*ADDR_W-1:0] dec_target,
    input  logic [NUM_THREADS-1:0]        req_sent,
    input  logic [NUM_THREADS-1:0]        resp_ok,
    output logic [NUM_THREADS*4-1:0]      status,
    output logic [NUM_THREADS*ADDR_W-1:0] pc,
    output logic [NUM_THREADS*ADDR_W-1:0] npc,
    output logic [NUM_THREADS*ADDR_W-1:0] nnpc,
    output logic                          stage_active
);
    localparam int FW = NUM_THREADS * NUM_STAGES;

    logic [FW-1:0]          blk_all;
    logic [FW-1:0]          ublk_all;
    logic [FW-1:0]          stall_q;
    logic [FW-1:0]          stall_nx;
    fstat_e                 st [NUM_THREADS];

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        localparam int FB = t * NUM_STAGES;
        logic stalled;

        assign blk_all[FB +: NUM_STAGES]  = {blk_cmt[t], blk_exe[t], blk_ren[t], blk_dec[t]};
        assign ublk_all[FB +: NUM_STAGES] = {unblk_cmt[t], unblk_exe[t], unblk_ren[t], unblk_dec[t]};

        fsc_stall_tracker #(.NS(NUM_STAGES)) u_stall (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (blk_all[FB +: NUM_STAGES]),
            .clr_i      (ublk_all[FB +: NUM_STAGES]),
            .flags_q    (stall_q[FB +: NUM_STAGES]),
            .flags_next (stall_nx[FB +: NUM_STAGES])
        );

        assign stalled = ctx_switch | (|stall_nx[FB +: NUM_STAGES]);

        fsc_thread_fsm #(
            .ADDR_W   (ADDR_W),
            .STEP     (INST_BYTES),
            .RESET_PC (RESET_PC)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmt_sq   (cmt_squash[t]),
            .cmt_tgt  (cmt_target[t*ADDR_W +: ADDR_W]),
            .rob_sq   (rob_squashing[t]),
            .dec_sq   (dec_squash[t]),
            .dec_tgt  (dec_target[t*ADDR_W +: ADDR_W]),
            .stalled  (stalled),
            .req_sent (req_sent[t]),
            .resp_ok  (resp_ok[t]),
            .st_q     (st[t]),
            .pc_q     (pc[t*ADDR_W +: ADDR_W]),
            .npc_q    (npc[t*ADDR_W +: ADDR_W]),
            .nnpc_q   (nnpc[t*ADDR_W +: ADDR_W])
        );

        assign status[t*STAT_W +: STAT_W] = st[t];
    end

    // output decode of stage activity
    always_comb begin
        stage_active = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (thread_active[t] &&
                (st[t] == ST_RUN || st[t] == ST_SQUASH || st[t] == ST_DONE))
                stage_active = 1'b1;
        end
    end
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import fsc_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int ADDR_W      = 32,
    parameter int STEP        = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_THREADS-1:0]        thread_active,
    input logic [NUM_THREADS*4-1:0]      blk_all,
    input logic [NUM_THREADS*4-1:0]      ublk_all,
    input logic [NUM_THREADS*4-1:0]      stall_q,
    input logic                          ctx_switch,
    input logic [NUM_THREADS-1:0]        cmt_squash,
    input logic [NUM_THREADS*ADDR_W-1:0] cmt_target,
    input logic [NUM_THREADS-1:0]        rob_squashing,
    input logic [NUM_THREADS-1:0]        dec_squash,
    input logic [NUM_THREADS*4-1:0]      status,
    input logic [NUM_THREADS*ADDR_W-1:0] pc,
    input logic [NUM_THREADS*ADDR_W-1:0] npc,
    input logic [NUM_THREADS*ADDR_W-1:0] nnpc,
    input logic                          stage_active
);
    for (genvar i = 0; i < NUM_THREADS * 4; i++) begin : g_flag
        a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            blk_all[i] |=> stall_q[i]);
        a_r2_unblock_legal: assert property (@(posedge clk) disable iff (!rst_n)
            ublk_all[i] |-> (!blk_all[i] && stall_q[i]));
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
        a_r3_commit_redirect: assert property (@(posedge clk) disable iff (!rst_n)
            cmt_squash[t] |=> (status[t*4 +: 4] == 4'(ST_SQUASH)) &&
                (pc[t*ADDR_W +: ADDR_W] == $past(cmt_target[t*ADDR_W +: ADDR_W])));
        a_r4_rob_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmt_squash[t] && rob_squashing[t]) |=>
                (status[t*4 +: 4] == 4'(ST_SQUASH)) && $stable(pc[t*ADDR_W +: ADDR_W]));
        a_r5_dec_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmt_squash[t] && dec_squash[t] && status[t*4 +: 4] == 4'(ST_SQUASH))
                |=> $stable(pc[t*ADDR_W +: ADDR_W]));
        a_r6_ctx_block: assert property (@(posedge clk) disable iff (!rst_n)
            (ctx_switch && !cmt_squash[t] && !rob_squashing[t] && !dec_squash[t] &&
             status[t*4 +: 4] != 4'(ST_WRESP)) |=> status[t*4 +: 4] == 4'(ST_BLOCK));
        a_r8_triple: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |-> (npc[t*ADDR_W +: ADDR_W] == pc[t*ADDR_W +: ADDR_W] + ADDR_W'(STEP)) &&
                     (nnpc[t*ADDR_W +: ADDR_W] == pc[t*ADDR_W +: ADDR_W] + ADDR_W'(2*STEP)));
        a_r10_active: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_active[t] && (status[t*4 +: 4] == 4'(ST_RUN) ||
             status[t*4 +: 4] == 4'(ST_SQUASH))) |-> stage_active);
        a_r11_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |-> status[t*4 +: 4] <= 4'd8);
    end
endmodule

bind fetch_status_ctl fsc_checker #(
    .NUM_THREADS (NUM_THREADS),
    .ADDR_W      (ADDR_W),
    .STEP        (INST_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .thread_active (thread_active),
    .blk_all       (blk_all),
    .ublk_all      (ublk_all),
    .stall_q       (stall_q),
    .ctx_switch    (ctx_switch),
    .cmt_squash    (cmt_squash),
    .cmt_target    (cmt_target),
    .rob_squashing (rob_squashing),
    .dec_squash    (dec_squash),
    .status        (status),
    .pc            (pc),
    .npc           (npc),
    .nnpc          (nnpc),
    .stage_active  (stage_active)
);

// File: tb/fetch_status_ctl_test.sv
`timescale 1ns/1ps
module fetch_status_ctl_test;
    localparam int T  = 2;
    localparam int AW = 32;
    localparam logic [31:0] RPC  = 32'h100;
    localparam logic [31:0] CTGT = 32'h1000;
    localparam logic [31:0] DTGT = 32'h2000;

    typedef struct packed {
        logic        cs;
        logic        rob;
        logic        dsq;
        logic [3:0]  blk;
        logic [3:0]  ublk;
        logic        ctx;
        logic        iss;
        logic        rsp;
        logic [3:0]  st;
        logic [31:0] epc;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd0,32'h100 },
        '{1'b1,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd2,32'h1000},
        '{1'b0,1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,4'd2,32'h2000},
        '{1'b0,1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd2,32'h2000},
        '{1'b1,1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,4'd2,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b0,4'h1,4'h0,1'b0,1'b0,1'b0,4'd3,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd3,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h1,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b0,4'h8,4'h0,1'b0,1'b0,1'b0,4'd3,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h8,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b1,1'b0,1'b0,4'd3,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b1,1'b0,4'd5,32'h1000},
        '{1'b0,1'b0,1'b0,4'h2,4'h0,1'b0,1'b0,1'b0,4'd5,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,4'd3,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h2,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b1,1'b0,4'd5,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,4'd6,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd0,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b1,1'b0,4'd5,32'h1000},
        '{1'b1,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd2,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,4'd0,32'h1000},
        '{1'b1,1'b0,1'b0,4'h4,4'h0,1'b0,1'b0,1'b0,4'd2,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,4'd3,32'h1000},
        '{1'b0,1'b0,1'b0,4'h0,4'h4,1'b0,1'b0,1'b0,4'd0,32'h1000}
    };

    // requirement exercised by each table row
    function automatic string row_req(int i);
        case (i)
            0:               return "R1";
            1, 6, 23, 25:    return "R3";
            2:               return "R5";
            4:               return "R8";
            5:               return "R4";
            3, 7, 14, 24:    return "R7";
            8, 9, 10, 11, 12, 26, 27: return "R2";
            13, 16:          return "R6";
            default:         return "R9";
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst_n;
    logic [T-1:0] thread_active, blk_dec, unblk_dec, blk_ren, unblk_ren;
    logic [T-1:0] blk_exe, unblk_exe, blk_cmt, unblk_cmt;
    logic ctx_switch;
    logic [T-1:0] cmt_squash, rob_squashing, dec_squash, req_sent, resp_ok;
    logic [T*AW-1:0] cmt_target, dec_target;
    logic [T*4-1:0]  status;
    logic [T*AW-1:0] pc, npc, nnpc;
    logic stage_active;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fetch_status_ctl #(.NUM_THREADS(T), .ADDR_W(AW), .INST_BYTES(4), .RESET_PC(RPC)) uut (
        .clk(clk), .rst_n(rst_n), .thread_active(thread_active),
        .blk_dec(blk_dec), .unblk_dec(unblk_dec), .blk_ren(blk_ren), .unblk_ren(unblk_ren),
        .blk_exe(blk_exe), .unblk_exe(unblk_exe), .blk_cmt(blk_cmt), .unblk_cmt(unblk_cmt),
        .ctx_switch(ctx_switch), .cmt_squash(cmt_squash), .cmt_target(cmt_target),
        .rob_squashing(rob_squashing), .dec_squash(dec_squash), .dec_target(dec_target),
        .req_sent(req_sent), .resp_ok(resp_ok), .status(status), .pc(pc), .npc(npc),
        .nnpc(nnpc), .stage_active(stage_active)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_pulses();
        blk_dec = '0; unblk_dec = '0; blk_ren = '0; unblk_ren = '0;
        blk_exe = '0; unblk_exe = '0; blk_cmt = '0; unblk_cmt = '0;
        ctx_switch = 1'b0; cmt_squash = '0; rob_squashing = '0;
        dec_squash = '0; req_sent = '0; resp_ok = '0;
    endtask

    // one rising edge between drive and sample
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        thread_active = '1;
        cmt_target = {CTGT + 32'h10, CTGT};
        dec_target = {32'h3000, DTGT};
        clear_pulses();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 Running encoded as 0
        check("R1", "t0 status", 64'(status[3:0]), 64'd0);
        check("R11", "t1 status", 64'(status[7:4]), 64'd0);
        check("R1", "t0 pc", 64'(pc[31:0]), 64'(RPC));
        check("R1", "t0 npc", 64'(npc[31:0]), 64'(RPC + 4));
        check("R1", "t0 nnpc", 64'(nnpc[31:0]), 64'(RPC + 8));
        check("R10", "active after reset", 64'(stage_active), 64'd1);

        // table walk on thread 0, thread 1 kept quiet
        for (int i = 0; i < NV; i++) begin
            cmt_squash[0]    = VEC[i].cs;
            rob_squashing[0] = VEC[i].rob;
            dec_squash[0]    = VEC[i].dsq;
            blk_dec[0] = VEC[i].blk[0];  unblk_dec[0] = VEC[i].ublk[0];
            blk_ren[0] = VEC[i].blk[1];  unblk_ren[0] = VEC[i].ublk[1];
            blk_exe[0] = VEC[i].blk[2];  unblk_exe[0] = VEC[i].ublk[2];
            blk_cmt[0] = VEC[i].blk[3];  unblk_cmt[0] = VEC[i].ublk[3];
            ctx_switch  = VEC[i].ctx;
            req_sent[0] = VEC[i].iss;
            resp_ok[0]  = VEC[i].rsp;
            tick();
            clear_pulses();
            check(row_req(i), $sformatf("row %0d status", i), 64'(status[3:0]), 64'(VEC[i].st));
            check(row_req(i), $sformatf("row %0d pc", i), 64'(pc[31:0]), 64'(VEC[i].epc));
            check("R8", $sformatf("row %0d npc", i), 64'(npc[31:0]), 64'(VEC[i].epc + 4));
            check("R8", $sformatf("row %0d nnpc", i), 64'(nnpc[31:0]), 64'(VEC[i].epc + 8));
            // ctx_switch stalls thread 1 too
            check("R12", $sformatf("row %0d t1 status", i), 64'(status[7:4]),
                  VEC[i].ctx ? 64'd3 : 64'd0);
        end

        // R10: inactive threads do not count
        thread_active = 2'b01;
        blk_dec[0] = 1'b1;
        tick();
        clear_pulses();
        check("R10", "only blocked active thread", 64'(stage_active), 64'd0);
        thread_active = 2'b11;
        #1;
        check("R10", "running t1 made active", 64'(stage_active), 64'd1);
        unblk_dec[0] = 1'b1;
        tick();
        clear_pulses();
        check("R2", "unblock releases t0", 64'(status[3:0]), 64'd0);

        // R12: decode squash on thread 1 only
        dec_squash[1] = 1'b1;
        tick();
        clear_pulses();
        check("R12", "t1 squashing", 64'(status[7:4]), 64'd2);
        check("R12", "t1 pc redirected", 64'(pc[63:32]), 64'h3000);
        check("R12", "t1 nnpc", 64'(nnpc[63:32]), 64'h3008);
        check("R12", "t0 untouched", 64'(pc[31:0]), 64'(CTGT));
        check("R12", "t0 still running", 64'(status[3:0]), 64'd0);

        // R9: response while Running is ignored
        resp_ok[0] = 1'b1;
        tick();
        clear_pulses();
        check("R9", "stray response", 64'(status[3:0]), 64'd0);

        // R4 with a block pending: squash wins, then Blocked
        rob_squashing[0] = 1'b1;
        blk_ren[0] = 1'b1;
        tick();
        clear_pulses();
        check("R4", "rob over stall", 64'(status[3:0]), 64'd2);
        tick();
        check("R6", "stall after rob", 64'(status[3:0]), 64'd3);
        unblk_ren[0] = 1'b1;
        tick();
        clear_pulses();
        check("R7", "back to running", 64'(status[3:0]), 64'd0);

        // reset in mid-run restores R1 state
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R1", "t1 pc after reset", 64'(pc[63:32]), 64'(RPC));
        check("R1", "t1 status after reset", 64'(status[7:4]), 64'd0);

        summary();
    end
endmodule